// File: doc/BRIEF.md
# Mismatch Substitution Thread Spawner

This block feeds one mismatch-tolerant search engine in a chain of read-mapping engines. Engine 0 searches for exact matches; engine i tolerates i substituted bases. When the previous engine gives up on a read, this block turns that read into three new search threads. Each thread carries the same read ID and replaces the base that failed with one of the three other bases. Each thread restarts from the pointer pair that held just before the failing step. The block then merges these new threads into the engine's update queue. Threads already running in the engine go first.

The block also sorts what the engine hands back after each step. A thread that completed a step re-enters the update queue with its fresh flag cleared. A thread that matched goes out on the hit port, tagged with this stage's mismatch count. A thread that failed on its very first step after spawning is dropped. A thread that failed later is handed on to the next mismatch stage in the same record form the block itself accepts.

Base codes are A=00, C=01, G=10 and T=11. Read character index j occupies bits [2j+1:2j] of a read vector. A failure reported at iteration k (1..READ_LEN) concerns character index k-1.

The spawner is a state machine with four states:
- SP_IDLE: waits for a failing read.
- SP_ALT0, SP_ALT1, SP_ALT2: present copies 0, 1 and 2.

Its transitions are:
- SP_IDLE to SP_ALT0 when a failing read is accepted.
- SP_ALT0 to SP_ALT1 when copy 0 is accepted.
- SP_ALT1 to SP_ALT2 when copy 1 is accepted.
- SP_ALT2 to SP_IDLE when copy 2 is accepted.
- Each state holds while its copy is not accepted.

Top module: `mm_thread_spawner`

## Requirements
- R1: After reset, fl_ready is 1 and up_valid, fw_valid and hit_valid are 0.
- R2: Each failing read accepted on the fl port yields exactly three records on the up port with up_fresh=1. Each carries the same ID and the same top/bottom pointers, and its iteration equals the failing iteration minus one.
- R3: In copy n (n=0,1,2), character index k-1 holds the n-th smallest base code that differs from the original base there. All other characters are unchanged.
- R4: fl_ready is 0 from the cycle after a failing read is accepted until its third copy has been accepted. It is 1 at all other times.
- R5: A return of kind STEP (rt_kind=00) appears on the up port in the same cycle, with up_fresh=0 and all fields unchanged. While it is valid it owns the up port and the spawner copy waits, and rt_ready equals up_ready.
- R6: A spawner copy that is not accepted is held unchanged until it is.
- R7: A return of kind EMPTY (01) with rt_fresh=1 is consumed at once (rt_ready=1) and produces no output.
- R8: A return of kind EMPTY with rt_fresh=0 is presented unchanged on the fw port, and rt_ready equals fw_ready.
- R9: A return of kind HIT (10) is presented on the hit port with its ID and pointers and hit_mm equal to the STAGE parameter, and rt_ready equals hit_ready.
- R10: A return of kind 11 is consumed at once and produces no output.
- R11: Each output stream keeps the order of its source: copies in spawn order, step records, forwarded records and hits in return order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_valid | input | 1 | Failing read from previous engine valid |
| fl_ready | output | 1 | Spawner can accept a failing read |
| fl_id | input | ID_W | Read ID |
| fl_read | input | 2*READ_LEN | Read bases |
| fl_iter | input | CNT_W | Iteration k at which the read failed |
| fl_top | input | PTR_W | Top pointer of iteration k-1 |
| fl_bot | input | PTR_W | Bottom pointer of iteration k-1 |
| rt_valid | input | 1 | Engine step result valid |
| rt_ready | output | 1 | Step result consumed |
| rt_kind | input | 2 | 00 STEP, 01 EMPTY, 10 HIT, 11 void |
| rt_fresh | input | 1 | Thread was on its first step since spawning |
| rt_id | input | ID_W | Thread read ID |
| rt_read | input | 2*READ_LEN | Thread read bases |
| rt_iter | input | CNT_W | Thread iteration count |
| rt_top | input | PTR_W | Thread top pointer |
| rt_bot | input | PTR_W | Thread bottom pointer |
| up_valid | output | 1 | Update-queue record valid |
| up_ready | input | 1 | Update queue accepts |
| up_id | output | ID_W | Record read ID |
| up_read | output | 2*READ_LEN | Record read bases |
| up_iter | output | CNT_W | Record iteration count |
| up_top | output | PTR_W | Record top pointer |
| up_bot | output | PTR_W | Record bottom pointer |
| up_fresh | output | 1 | Record is a newly spawned copy |
| fw_valid | output | 1 | Failed record for next stage valid |
| fw_ready | input | 1 | Next stage accepts |
| fw_id | output | ID_W | Forwarded read ID |
| fw_read | output | 2*READ_LEN | Forwarded read bases |
| fw_iter | output | CNT_W | Forwarded failing iteration |
| fw_top | output | PTR_W | Forwarded top pointer |
| fw_bot | output | PTR_W | Forwarded bottom pointer |
| hit_valid | output | 1 | Match report valid |
| hit_ready | input | 1 | Match consumer accepts |
| hit_id | output | ID_W | Matched read ID |
| hit_top | output | PTR_W | Final top pointer |
| hit_bot | output | PTR_W | Final bottom pointer |
| hit_mm | output | MM_W | Mismatch count of this stage |

## Verification
A STEP return from the engine and a pending spawned copy can compete for the update port in the same cycle. The bench drives return traffic and failing reads from two concurrent random streams, so a STEP return often arrives while the spawner sits in one of its copy states. In each such cycle the bench requires the up port to show the STEP record with the fresh flag clear. It requires the displaced copy to appear later, intact and in its ascending-base position, in the separate stream of fresh records.

// File: rtl/mts_pkg.sv
package mts_pkg;

    typedef enum logic [1:0] {
        RK_STEP  = 2'b00,
        RK_EMPTY = 2'b01,
        RK_HIT   = 2'b10,
        RK_VOID  = 2'b11
    } ret_kind_e;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_ALT0,
        SP_ALT1,
        SP_ALT2
    } sp_state_e;

    // n-th smallest base code that differs from orig (n = 0..2)
    function automatic logic [1:0] alt_base(input logic [1:0] orig, input logic [1:0] slot);
        return (slot < orig) ? slot : slot + 2'd1;
    endfunction

endpackage

// File: rtl/mts_sub_gen.sv
module mts_sub_gen
    import mts_pkg::*;
#(
    parameter int READ_LEN = 8,
    parameter int ID_W     = 6,
    parameter int PTR_W    = 12,
    parameter int CNT_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [ID_W-1:0]       in_id,
    input  logic [2*READ_LEN-1:0] in_read,
    input  logic [CNT_W-1:0]      in_iter,
    input  logic [PTR_W-1:0]      in_top,
    input  logic [PTR_W-1:0]      in_bot,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ID_W-1:0]       out_id,
    output logic [2*READ_LEN-1:0] out_read,
    output logic [CNT_W-1:0]      out_iter,
    output logic [PTR_W-1:0]      out_top,
    output logic [PTR_W-1:0]      out_bot
);

    sp_state_e             state, nxt;
    logic [ID_W-1:0]       h_id;
    logic [2*READ_LEN-1:0] h_read;
    logic [CNT_W-1:0]      h_iter;
    logic [PTR_W-1:0]      h_top;
    logic [PTR_W-1:0]      h_bot;
    logic [CNT_W-1:0]      pos;
    logic [1:0]            orig;
    logic [1:0]            slot;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= nxt;
    end

    // captured failing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_id   <= '0;
            h_read <= '0;
            h_iter <= '0;
            h_top  <= '0;
            h_bot  <= '0;
        end else if (in_valid && in_ready) begin
            h_id   <= in_id;
            h_read <= in_read;
            h_iter <= in_iter;
            h_top  <= in_top;
            h_bot  <= in_bot;
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        slot      = 2'd0;
        unique case (state)
            SP_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) nxt = SP_ALT0;
            end
            SP_ALT0: begin
                out_valid = 1'b1;
                slot      = 2'd0;
                if (out_ready) nxt = SP_ALT1;
            end
            SP_ALT1: begin
                out_valid = 1'b1;
                slot      = 2'd1;
                if (out_ready) nxt = SP_ALT2;
            end
            SP_ALT2: begin
                out_valid = 1'b1;
                slot      = 2'd2;
                if (out_ready) nxt = SP_IDLE;
            end
        endcase
    end

    // substituted copy
    always_comb begin
        pos  = h_iter - 1'b1;
        orig = 2'b00;
        for (int i = 0; i < READ_LEN; i++) begin
            if (pos == CNT_W'(i)) orig = h_read[2*i +: 2];
        end
        out_read = h_read;
        for (int i = 0; i < READ_LEN; i++) begin
            if (pos == CNT_W'(i)) out_read[2*i +: 2] = alt_base(orig, slot);
        end
        out_id   = h_id;
        out_iter = pos;
        out_top  = h_top;
        out_bot  = h_bot;
    end

endmodule

// File: rtl/mts_ret_route.sv
module mts_ret_route
    import mts_pkg::*;
(
    input  logic       rt_valid,
    input  logic [1:0] rt_kind,
    input  logic       rt_fresh,
    output logic       rt_ready,
    output logic       step_valid,
    input  logic       step_ready,
    output logic       fw_valid,
    input  logic       fw_ready,
    output logic       hit_valid,
    input  logic       hit_ready
);

    always_comb begin
        step_valid = 1'b0;
        fw_valid   = 1'b0;
        hit_valid  = 1'b0;
        rt_ready   = 1'b1;
        unique case (ret_kind_e'(rt_kind))
            RK_STEP: begin
                step_valid = rt_valid;
                rt_ready   = step_ready;
            end
            RK_EMPTY: begin
                if (!rt_fresh) begin
                    fw_valid = rt_valid;
                    rt_ready = fw_ready;
                end
            end
            RK_HIT: begin
                hit_valid = rt_valid;
                rt_ready  = hit_ready;
            end
            RK_VOID: rt_ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/mts_upd_merge.sv
module mts_upd_merge #(
    parameter int REC_W = 50
) (
    input  logic             step_valid,
    output logic             step_ready,
    input  logic [REC_W-1:0] step_rec,
    input  logic             sp_valid,
    output logic             sp_ready,
    input  logic [REC_W-1:0] sp_rec,
    output logic             up_valid,
    input  logic             up_ready,
    output logic [REC_W-1:0] up_rec,
    output logic             up_fresh
);

    always_comb begin
        step_ready = up_ready;
        sp_ready   = up_ready && !step_valid;
        up_valid   = step_valid || sp_valid;
        up_rec     = step_valid ? step_rec : sp_rec;
        up_fresh   = !step_valid && sp_valid;
    end

endmodule

// File: rtl/mm_thread_spawner.sv
module mm_thread_spawner #(
    parameter int READ_LEN = 8,
    parameter int ID_W     = 6,
    parameter int PTR_W    = 12,
    parameter int CNT_W    = $clog2(READ_LEN + 1),
    parameter int STAGE    = 1,
    parameter int MM_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fl_valid,
    output logic                  fl_ready,
    input  logic [ID_W-1:0]       fl_id,
    input  logic [2*READ_LEN-1:0] fl_read,
    input  logic [CNT_W-1:0]      fl_iter,
    input  logic [PTR_W-1:0]      fl_top,
    input  logic [PTR_W-1:0]      fl_bot,
    input  logic                  rt_valid,
    output logic                  rt_ready,
    input  logic [1:0]            rt_kind,
    input  logic                  rt_fresh,
    input  logic [ID_W-1:0]       rt_id,
    input  logic [2*READ_LEN-1:0] rt_read,
    input  logic [CNT_W-1:0]      rt_iter,
    input  logic [PTR_W-1:0]      rt_top,
    input  logic [PTR_W-1:0]      rt_bot,
    output logic                  up_valid,
    input  logic                  up_ready,
    output logic [ID_W-1:0]       up_id,
    output logic [2*READ_LEN-1:0] up_read,
    output logic [CNT_W-1:0]      up_iter,
    output logic [PTR_W-1:0]      up_top,
    output logic [PTR_W-1:0]      up_bot,
    output logic                  up_fresh,
    output logic                  fw_valid,
    input  logic                  fw_ready,
    output logic [ID_W-1:0]       fw_id,
    output logic [2*READ_LEN-1:0] fw_read,
    output logic [CNT_W-1:0]      fw_iter,
    output logic [PTR_W-1:0]      fw_top,
    output logic [PTR_W-1:0]      fw_bot,
    output logic                  hit_valid,
    input  logic                  hit_ready,
    output logic [ID_W-1:0]       hit_id,
    output logic [PTR_W-1:0]      hit_top,
    output logic [PTR_W-1:0]      hit_bot,
    output logic [MM_W-1:0]       hit_mm
);

    localparam int REC_W = ID_W + 2*READ_LEN + CNT_W + 2*PTR_W;

    logic                  sp_valid, sp_ready;
    logic [ID_W-1:0]       sp_id;
    logic [2*READ_LEN-1:0] sp_read;
    logic [CNT_W-1:0]      sp_iter;
    logic [PTR_W-1:0]      sp_top, sp_bot;
    logic                  step_valid, step_ready;
    logic [REC_W-1:0]      step_rec, sp_rec, up_rec;

    mts_sub_gen #(
        .READ_LEN(READ_LEN), .ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) gen_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(fl_valid), .in_ready(fl_ready),
        .in_id(fl_id), .in_read(fl_read), .in_iter(fl_iter),
        .in_top(fl_top), .in_bot(fl_bot),
        .out_valid(sp_valid), .out_ready(sp_ready),
        .out_id(sp_id), .out_read(sp_read), .out_iter(sp_iter),
        .out_top(sp_top), .out_bot(sp_bot)
    );

    mts_ret_route route_i (
        .rt_valid(rt_valid), .rt_kind(rt_kind), .rt_fresh(rt_fresh),
        .rt_ready(rt_ready),
        .step_valid(step_valid), .step_ready(step_ready),
        .fw_valid(fw_valid), .fw_ready(fw_ready),
        .hit_valid(hit_valid), .hit_ready(hit_ready)
    );

    assign step_rec = {rt_id, rt_read, rt_iter, rt_top, rt_bot};
    assign sp_rec   = {sp_id, sp_read, sp_iter, sp_top, sp_bot};

    mts_upd_merge #(.REC_W(REC_W)) merge_i (
        .step_valid(step_valid), .step_ready(step_ready), .step_rec(step_rec),
        .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_rec(sp_rec),
        .up_valid(up_valid), .up_ready(up_ready), .up_rec(up_rec),
        .up_fresh(up_fresh)
    );

    assign {up_id, up_read, up_iter, up_top, up_bot} = up_rec;

    assign fw_id   = rt_id;
    assign fw_read = rt_read;
    assign fw_iter = rt_iter;
    assign fw_top  = rt_top;
    assign fw_bot  = rt_bot;

    assign hit_id  = rt_id;
    assign hit_top = rt_top;
    assign hit_bot = rt_bot;
    assign hit_mm  = MM_W'(STAGE);

endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
    parameter int READ_LEN = 8,
    parameter int ID_W     = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fl_valid,
    input logic                  fl_ready,
    input logic                  rt_valid,
    input logic [1:0]            rt_kind,
    input logic                  rt_fresh,
    input logic                  rt_ready,
    input logic                  up_valid,
    input logic                  up_fresh,
    input logic                  fw_valid,
    input logic                  hit_valid,
    input logic                  sp_valid,
    input logic                  sp_ready,
    input logic [ID_W-1:0]       sp_id,
    input logic [2*READ_LEN-1:0] sp_read
);

    a_r4_input_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && fl_ready |=> !fl_ready);

    a_r6_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid && !sp_ready |=> sp_valid && $stable(sp_read) && $stable(sp_id));

    a_r5_step_first: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && rt_kind == 2'b00 |-> up_valid && !up_fresh && !sp_ready);

    a_r2_copy_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid && sp_ready |-> up_valid && up_fresh);

    a_r7_fresh_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && rt_kind == 2'b01 && rt_fresh |-> rt_ready && !fw_valid && !hit_valid);

    a_r10_void_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid && rt_kind == 2'b11 |-> rt_ready && !fw_valid && !hit_valid);

endmodule

bind mm_thread_spawner mts_checker #(.READ_LEN(READ_LEN), .ID_W(ID_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .fl_valid(fl_valid), .fl_ready(fl_ready),
    .rt_valid(rt_valid), .rt_kind(rt_kind), .rt_fresh(rt_fresh), .rt_ready(rt_ready),
    .up_valid(up_valid), .up_fresh(up_fresh), .fw_valid(fw_valid), .hit_valid(hit_valid),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_id(sp_id), .sp_read(sp_read)
);

// File: tb/mm_thread_spawner_tb_top.sv
`timescale 1ns/1ps
module mm_thread_spawner_tb_top;

    localparam int READ_LEN = 8;
    localparam int ID_W     = 6;
    localparam int PTR_W    = 12;
    localparam int CNT_W    = $clog2(READ_LEN + 1);
    localparam int STAGE    = 1;
    localparam int MM_W     = 2;
    localparam int REC_W    = ID_W + 2*READ_LEN + CNT_W + 2*PTR_W;
    localparam int HIT_W    = ID_W + 2*PTR_W + MM_W;

    typedef logic [REC_W-1:0] rec_t;
    typedef logic [HIT_W-1:0] hrec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                  fl_valid = 1'b0, fl_ready;
    logic [ID_W-1:0]       fl_id = '0;
    logic [2*READ_LEN-1:0] fl_read = '0;
    logic [CNT_W-1:0]      fl_iter = '0;
    logic [PTR_W-1:0]      fl_top = '0, fl_bot = '0;
    logic                  rt_valid = 1'b0, rt_ready, rt_fresh = 1'b0;
    logic [1:0]            rt_kind = 2'b00;
    logic [ID_W-1:0]       rt_id = '0;
    logic [2*READ_LEN-1:0] rt_read = '0;
    logic [CNT_W-1:0]      rt_iter = '0;
    logic [PTR_W-1:0]      rt_top = '0, rt_bot = '0;
    logic                  up_valid, up_ready = 1'b0, up_fresh;
    logic [ID_W-1:0]       up_id;
    logic [2*READ_LEN-1:0] up_read;
    logic [CNT_W-1:0]      up_iter;
    logic [PTR_W-1:0]      up_top, up_bot;
    logic                  fw_valid, fw_ready = 1'b0;
    logic [ID_W-1:0]       fw_id;
    logic [2*READ_LEN-1:0] fw_read;
    logic [CNT_W-1:0]      fw_iter;
    logic [PTR_W-1:0]      fw_top, fw_bot;
    logic                  hit_valid, hit_ready = 1'b0;
    logic [ID_W-1:0]       hit_id;
    logic [PTR_W-1:0]      hit_top, hit_bot;
    logic [MM_W-1:0]       hit_mm;

    mm_thread_spawner #(
        .READ_LEN(READ_LEN), .ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W),
        .STAGE(STAGE), .MM_W(MM_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_id(fl_id), .fl_read(fl_read),
        .fl_iter(fl_iter), .fl_top(fl_top), .fl_bot(fl_bot),
        .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_kind(rt_kind), .rt_fresh(rt_fresh),
        .rt_id(rt_id), .rt_read(rt_read), .rt_iter(rt_iter), .rt_top(rt_top), .rt_bot(rt_bot),
        .up_valid(up_valid), .up_ready(up_ready), .up_id(up_id), .up_read(up_read),
        .up_iter(up_iter), .up_top(up_top), .up_bot(up_bot), .up_fresh(up_fresh),
        .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_id(fw_id), .fw_read(fw_read),
        .fw_iter(fw_iter), .fw_top(fw_top), .fw_bot(fw_bot),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_id(hit_id),
        .hit_top(hit_top), .hit_bot(hit_bot), .hit_mm(hit_mm)
    );

    int n_chk = 0;
    int n_fail = 0;
    int fl_acc = 0;
    int cp_acc = 0;
    bit done = 1'b0;
    rec_t  q_cp[$];
    rec_t  q_step[$];
    rec_t  q_fw[$];
    hrec_t q_hit[$];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // expected copies: ascending codes, skipping the original base
    task automatic expect_copies(input logic [ID_W-1:0] id, input logic [2*READ_LEN-1:0] rd,
                                 input int k, input logic [PTR_W-1:0] tp, input logic [PTR_W-1:0] bt);
        logic [1:0] orig;
        logic [2*READ_LEN-1:0] r2;
        orig = rd[2*(k-1) +: 2];
        for (int b = 0; b < 4; b++) begin
            if (b[1:0] != orig) begin
                r2 = rd;
                r2[2*(k-1) +: 2] = b[1:0];
                q_cp.push_back({id, r2, CNT_W'(k-1), tp, bt});
            end
        end
    endtask

    task automatic send_fl(input logic [ID_W-1:0] id, input logic [2*READ_LEN-1:0] rd,
                           input int k, input logic [PTR_W-1:0] tp, input logic [PTR_W-1:0] bt);
        expect_copies(id, rd, k, tp, bt);
        @(posedge clk); #1;
        fl_id = id; fl_read = rd; fl_iter = CNT_W'(k); fl_top = tp; fl_bot = bt;
        fl_valid = 1'b1;
        do @(negedge clk); while (!fl_ready);
        @(posedge clk); #1;
        fl_valid = 1'b0;
    endtask

    task automatic send_rt(input logic [1:0] kind, input bit fresh, input rec_t r);
        if (kind == 2'b00) q_step.push_back(r);
        if (kind == 2'b01 && !fresh) q_fw.push_back(r);
        if (kind == 2'b10) q_hit.push_back({r[REC_W-1 -: ID_W], r[2*PTR_W-1:0], MM_W'(STAGE)});
        @(posedge clk); #1;
        rt_kind = kind; rt_fresh = fresh;
        {rt_id, rt_read, rt_iter, rt_top, rt_bot} = r;
        rt_valid = 1'b1;
        do @(negedge clk); while (!rt_ready);
        @(posedge clk); #1;
        rt_valid = 1'b0;
    endtask

    function automatic rec_t rnd_rec();
        return {ID_W'($urandom), (2*READ_LEN)'($urandom), CNT_W'($urandom % (READ_LEN + 1)),
                PTR_W'($urandom), PTR_W'($urandom)};
    endfunction

    // random downstream readiness
    always @(posedge clk) begin
        #1;
        up_ready  = ($urandom % 4) != 0;
        fw_ready  = ($urandom % 3) != 0;
        hit_ready = ($urandom % 3) != 0;
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            rec_t uprec, rtrec, e;
            hrec_t h;
            bit busy;
            uprec = {up_id, up_read, up_iter, up_top, up_bot};
            rtrec = {rt_id, rt_read, rt_iter, rt_top, rt_bot};
            busy = (fl_acc * 3) != cp_acc;
            chk(fl_ready == !busy, "R4 input stall", 128'(fl_ready), 128'(!busy));
            if (rt_valid && rt_kind == 2'b00)
                chk(up_valid && !up_fresh && uprec == rtrec && rt_ready == up_ready,
                    "R5 step priority", 128'(uprec), 128'(rtrec));
            if (rt_valid && ((rt_kind == 2'b01 && rt_fresh) || rt_kind == 2'b11))
                chk(rt_ready && !fw_valid && !hit_valid && !(up_valid && !up_fresh),
                    (rt_kind == 2'b11) ? "R10 void discard" : "R7 fresh drop",
                    128'({rt_ready, fw_valid, hit_valid}), 128'(3'b100));
            if (rt_valid && rt_kind == 2'b01 && !rt_fresh)
                chk(fw_valid && rt_ready == fw_ready, "R8 forward handshake",
                    128'({fw_valid, rt_ready}), 128'({1'b1, fw_ready}));
            if (rt_valid && rt_kind == 2'b10)
                chk(hit_valid && rt_ready == hit_ready && hit_mm == MM_W'(STAGE),
                    "R9 hit handshake", 128'({hit_valid, rt_ready, hit_mm}),
                    128'({1'b1, hit_ready, MM_W'(STAGE)}));
            if (up_valid && up_ready) begin
                if (up_fresh) begin
                    e = (q_cp.size() > 0) ? q_cp.pop_front() : '0;
                    chk(uprec == e, "R2 R3 R6 spawned copy", 128'(uprec), 128'(e));
                    cp_acc++;
                end else begin
                    e = (q_step.size() > 0) ? q_step.pop_front() : '0;
                    chk(uprec == e, "R11 step order", 128'(uprec), 128'(e));
                end
            end
            if (fw_valid && fw_ready) begin
                e = (q_fw.size() > 0) ? q_fw.pop_front() : '0;
                chk({fw_id, fw_read, fw_iter, fw_top, fw_bot} == e, "R8 R11 forward record",
                    128'({fw_id, fw_read, fw_iter, fw_top, fw_bot}), 128'(e));
            end
            if (hit_valid && hit_ready) begin
                h = (q_hit.size() > 0) ? q_hit.pop_front() : '0;
                chk({hit_id, hit_top, hit_bot, hit_mm} == h, "R9 R11 hit record",
                    128'({hit_id, hit_top, hit_bot, hit_mm}), 128'(h));
            end
            if (fl_valid && fl_ready) fl_acc++;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1;
        chk(fl_ready && !up_valid && !fw_valid && !hit_valid, "R1 reset state",
            128'({fl_ready, up_valid, fw_valid, hit_valid}), 128'(4'b1000));
        rst_n = 1'b1;

        // directed: failing first character with base A, last character with base T
        send_fl(6'h01, 16'h0000, 1, 12'h111, 12'h222);
        send_fl(6'h02, 16'hFFFF, READ_LEN, 12'h333, 12'h444);
        send_fl(6'h03, 16'h9C6B, 4, 12'h555, 12'h666);
        // directed returns of every kind
        send_rt(2'b01, 1'b1, rnd_rec());
        send_rt(2'b11, 1'b0, rnd_rec());
        send_rt(2'b01, 1'b0, rnd_rec());
        send_rt(2'b10, 1'b0, rnd_rec());
        send_rt(2'b00, 1'b0, rnd_rec());

        // concurrent random streams: STEP returns contend with spawned copies
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    send_fl(ID_W'($urandom), (2*READ_LEN)'($urandom),
                            1 + int'($urandom % READ_LEN), PTR_W'($urandom), PTR_W'($urandom));
                    repeat ($urandom % 3) @(posedge clk);
                end
            end
            begin
                for (int i = 0; i < 120; i++) begin
                    int r;
                    r = int'($urandom % 10);
                    if (r < 4)       send_rt(2'b00, 1'b0, rnd_rec());
                    else if (r < 6)  send_rt(2'b01, 1'($urandom), rnd_rec());
                    else if (r < 8)  send_rt(2'b10, 1'($urandom), rnd_rec());
                    else if (r == 8) send_rt(2'b11, 1'($urandom), rnd_rec());
                    else             send_rt(2'b01, 1'b0, rnd_rec());
                    repeat ($urandom % 2) @(posedge clk);
                end
            end
        join

        for (int i = 0; i < 200; i++) begin
            if (q_cp.size() == 0 && q_step.size() == 0 && q_fw.size() == 0 && q_hit.size() == 0) break;
            @(posedge clk);
        end
        repeat (2) @(posedge clk);
        chk(q_cp.size() == 0, "R2 all copies emitted", 128'(q_cp.size()), 128'(0));
        chk(q_step.size() == 0, "R5 all steps emitted", 128'(q_step.size()), 128'(0));
        chk(q_fw.size() == 0, "R8 all forwards emitted", 128'(q_fw.size()), 128'(0));
        chk(q_hit.size() == 0, "R9 all hits emitted", 128'(q_hit.size()), 128'(0));
        chk(fl_acc * 3 == cp_acc, "R2 three copies per read", 128'(cp_acc), 128'(fl_acc * 3));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule